// File: doc/BRIEF.md
# Smart card contact activation sequencer

This block powers one set of card contacts up and down in a fixed order. A host starts a session by pulling an active-low session command low. The block then turns on the card supply regulator, enables the I/O line, starts the card clock and finally hands the card reset line to the host. When the host raises the command again, the block tears the contacts down in the reverse order. A fault, card removal or supply alarm during a session starts the same teardown at once, without waiting for the host.

All timing is counted in half-units. One unit T is `UNIT_OSC` periods of a slow internal oscillator, and one oscillator period lasts `OSC_DIV` cycles of `clk`. Both are parameters, so a shortened T can be used. The time at which the card clock starts depends on the level of the host reset input. If it is low when the session starts, the clock starts with the I/O line. If it is high, the clock starts when the host drops it inside the window between I/O enable and reset hand-over. The block also decodes the card voltage selection. It enters a low-power stop state from idle, and it holds off new sessions for a while after reset or after a supply alarm.

Top module: `smartcard_seq`

## Requirements
- R1: While `rst_n` is low all outputs are low. After reset a hold-off of `HOLD_UNITS` units runs, and a session request made during it is ignored.
- R2: A falling edge of `cmd_n` in idle, with `card_present` high and `fault` and `supply_alarm` low, raises `vreg_en` after the next clock edge.
- R3: `vsel` is captured when a session starts and stays stable while `vreg_en` is high. The codes are 2'b10 when `sel_18` is high (this select has priority), 2'b01 when only `sel_5v3n` is high, and 2'b00 when both are low.
- R4: `io_en` rises exactly 8 half-units (4T) after the session starts and is never high without `vreg_en`.
- R5: If `host_rst` is low when the session starts, `clk_en` rises in the same cycle as `io_en`.
- R6: If `host_rst` is high when the session starts, `clk_en` rises one cycle after `host_rst` is sampled low while `io_en` is high, before reset hand-over. If `host_rst` is still high at hand-over, the clock stays off for the whole session, and later changes of `host_rst` have no effect on it.
- R7: `card_rst` is low until 14 half-units (7T) after the session starts. After that it follows `host_rst` directly.
- R8: A rising `cmd_n` during a session drops `card_rst` after the next edge. `clk_en` then drops 1 half-unit later, `io_en` 2 half-units later and `vreg_en` 3 half-units later. An output that was not yet on stays off throughout.
- R9: `fault` high, `card_present` low or `supply_alarm` high during a session triggers the same teardown as R8.
- R10: A session request is ignored when no card is present. It is also ignored when `cmd_n` is low without a fresh falling edge.
- R11: In idle, with `cmd_n`, `sel_18` and `sel_5v3n` all high, `stop_mode` rises after the next edge. A teardown in progress finishes before stop is entered. Leaving stop lowers `stop_mode` and restarts the hold-off.
- R12: `supply_alarm` high in idle restarts the hold-off, and the hold-off counts only once the alarm is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_n | input | 1 | Active-low session command from the host |
| host_rst | input | 1 | Reset request from the host |
| card_present | input | 1 | Debounced card presence, high when a card is inserted |
| fault | input | 1 | Overcurrent or overheat fault flag |
| supply_alarm | input | 1 | Host supply below its alarm threshold |
| sel_18 | input | 1 | Selects 1.8 V when high |
| sel_5v3n | input | 1 | Selects 5 V when high and 3 V when low |
| vreg_en | output | 1 | Card supply regulator enable |
| vsel | output | 2 | Latched voltage code |
| io_en | output | 1 | Card I/O line enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset contact level |
| stop_mode | output | 1 | Low-power stop state |

## Verification
The bench builds the block with `OSC_DIV`=1, `UNIT_OSC`=8 and `HOLD_UNITS`=3. A half-unit is then 4 clock cycles, and a whole activation lasts 56 cycles. This makes every step edge of activation and teardown reachable within a few hundred cycles. Each step edge can be sampled on both sides: the late-clock window, reset hand-over, teardown cut short before I/O enable, the hold-off after an alarm, and stop entry after a teardown.

// File: rtl/smartcard_seq.sv
module smartcard_seq #(
  parameter int OSC_DIV    = 4,
  parameter int UNIT_OSC   = 64,
  parameter int HOLD_UNITS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_n,
  input  logic       host_rst,
  input  logic       card_present,
  input  logic       fault,
  input  logic       supply_alarm,
  input  logic       sel_18,
  input  logic       sel_5v3n,
  output logic       vreg_en,
  output logic [1:0] vsel,
  output logic       io_en,
  output logic       clk_en,
  output logic       card_rst,
  output logic       stop_mode
);

  localparam int HALF   = OSC_DIV * UNIT_OSC / 2;
  localparam int CW     = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int H_HOLD = 2 * HOLD_UNITS;
  localparam int HMAX   = (H_HOLD > 14) ? H_HOLD : 14;
  localparam int HW     = $clog2(HMAX + 1);
  localparam int H_IO   = 8;
  localparam int H_RST  = 14;

  typedef enum logic [2:0] {S_HOLD, S_IDLE, S_STOP, S_ACT, S_ON, S_DN} st_t;

  st_t           st, nxt;
  logic [CW-1:0] cyc;
  logic [HW-1:0] h;
  logic          cmd_q, early, clk_run, io_had, restart;

  wire wrap     = (cyc == CW'(HALF - 1));
  wire timed    = (st == S_HOLD) || (st == S_ACT) || (st == S_DN);
  wire trig     = cmd_n | fault | ~card_present | supply_alarm;
  wire start    = cmd_q & ~cmd_n & card_present & ~fault & ~supply_alarm;
  wire stop_req = cmd_n & sel_18 & sel_5v3n;
  wire io_win   = (st == S_ACT) && (h >= HW'(H_IO));

  always_comb begin
    nxt     = st;
    restart = 1'b0;
    case (st)
      S_HOLD: if (supply_alarm) restart = 1'b1;
              else if (wrap && h == HW'(H_HOLD - 1)) nxt = S_IDLE;
      S_IDLE: if (supply_alarm) nxt = S_HOLD;
              else if (stop_req) nxt = S_STOP;
              else if (start) nxt = S_ACT;
      S_STOP: if (!stop_req) nxt = S_HOLD;
      S_ACT:  if (trig) nxt = S_DN;
              else if (wrap && h == HW'(H_RST - 1)) nxt = S_ON;
      S_ON:   if (trig) nxt = S_DN;
      S_DN:   if (wrap && h == HW'(2)) nxt = S_IDLE;
      default: nxt = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_HOLD;
      cyc     <= '0;
      h       <= '0;
      cmd_q   <= 1'b1;
      early   <= 1'b0;
      clk_run <= 1'b0;
      io_had  <= 1'b0;
      vsel    <= 2'b00;
    end else begin
      st    <= nxt;
      cmd_q <= cmd_n;
      if (nxt != st || restart) begin
        cyc <= '0;
        h   <= '0;
      end else if (timed) begin
        if (wrap) begin
          cyc <= '0;
          h   <= h + 1'b1;
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
      if (st == S_IDLE && nxt == S_ACT) begin
        vsel    <= sel_18 ? 2'b10 : (sel_5v3n ? 2'b01 : 2'b00);
        early   <= ~host_rst;
        clk_run <= 1'b0;
      end
      if (io_win && !host_rst) clk_run <= 1'b1;
      if (nxt == S_DN && st != S_DN) begin
        clk_run <= clk_en;
        io_had  <= io_en;
      end
      if (nxt == S_IDLE) clk_run <= 1'b0;
    end
  end

  assign vreg_en   = (st == S_ACT) || (st == S_ON) || (st == S_DN);
  assign io_en     = io_win || (st == S_ON) || (st == S_DN && io_had && h < HW'(2));
  assign clk_en    = (io_win && early) || ((st == S_ACT || st == S_ON) && clk_run)
                   || (st == S_DN && clk_run && h < HW'(1));
  assign card_rst  = (st == S_ON) && host_rst;
  assign stop_mode = (st == S_STOP);

endmodule

module smartcard_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_n,
  input logic       fault,
  input logic       vreg_en,
  input logic [1:0] vsel,
  input logic       io_en,
  input logic       clk_en,
  input logic       card_rst,
  input logic       stop_mode
);
  AST_IO_NEEDS_VREG: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vreg_en); // R4
  AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en); // R5
  AST_RST_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (io_en && vreg_en)); // R7
  AST_VSEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_en && $past(vreg_en)) |-> $stable(vsel)); // R3
  AST_CMD_DROPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_n |=> !card_rst); // R8
  AST_VREG_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vreg_en) |-> (!io_en && !clk_en)); // R8
  AST_FAULT_DROPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !card_rst); // R9
  AST_STOP_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> !vreg_en); // R11
endmodule

bind smartcard_seq smartcard_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .fault(fault), .vreg_en(vreg_en),
  .vsel(vsel), .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .stop_mode(stop_mode)
);

// File: tb/test_smartcard_seq.sv
module test_smartcard_seq;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_n = 1'b1, host_rst = 1'b0, card_present = 1'b1;
  logic fault = 1'b0, supply_alarm = 1'b0, sel_18 = 1'b0, sel_5v3n = 1'b0;
  logic vreg_en, io_en, clk_en, card_rst, stop_mode;
  logic [1:0] vsel;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  smartcard_seq #(.OSC_DIV(1), .UNIT_OSC(8), .HOLD_UNITS(3)) i_smartcard_seq (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .host_rst(host_rst),
    .card_present(card_present), .fault(fault), .supply_alarm(supply_alarm),
    .sel_18(sel_18), .sel_5v3n(sel_5v3n), .vreg_en(vreg_en), .vsel(vsel),
    .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst), .stop_mode(stop_mode));

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic activate(input string tag, input logic s18, input logic s5,
                          input logic hr, input int exp_vsel);
    sel_18 = s18; sel_5v3n = s5; host_rst = hr; cmd_n = 1'b0;
    step(1);
    check({tag, " R2 vreg on"}, vreg_en, 1);
    check({tag, " R3 vsel"}, vsel, exp_vsel);
  endtask

  task automatic teardown(input string tag, input int exp_clk, input int exp_io);
    step(1);
    check({tag, " R8 rst low"}, card_rst, 0);
    check({tag, " R8 clk early"}, clk_en, exp_clk);
    check({tag, " R8 io early"}, io_en, exp_io);
    step(3);
    check({tag, " R8 clk held"}, clk_en, exp_clk);
    step(1);
    check({tag, " R8 clk off"}, clk_en, 0);
    check({tag, " R8 io held"}, io_en, exp_io);
    step(4);
    check({tag, " R8 io off"}, io_en, 0);
    check({tag, " R8 vreg held"}, vreg_en, 1);
    step(3);
    check({tag, " R8 vreg held2"}, vreg_en, 1);
    step(1);
    check({tag, " R8 vreg off"}, vreg_en, 0);
  endtask

  task automatic t_reset;
    step(2);
    check("R1 vreg in reset", vreg_en, 0);
    check("R1 io in reset", io_en, 0);
    check("R1 clk in reset", clk_en, 0);
    check("R1 rst in reset", card_rst, 0);
    rst_n = 1'b1;
    step(3);
    cmd_n = 1'b0;
    step(3);
    check("R1 holdoff ignores start", vreg_en, 0);
    cmd_n = 1'b1;
    step(30);
  endtask

  task automatic t_early;
    activate("early", 1'b0, 1'b1, 1'b0, 1);
    step(31);
    check("R4 io before 4T", io_en, 0);
    check("R5 clk before 4T", clk_en, 0);
    step(1);
    check("R4 io at 4T", io_en, 1);
    check("R5 clk with io", clk_en, 1);
    sel_18 = 1'b1;
    step(1);
    check("R3 vsel latched", vsel, 1);
    sel_18 = 1'b0;
    step(15);
    host_rst = 1'b1;
    step(7);
    check("R7 rst held before 7T", card_rst, 0);
    step(1);
    check("R7 rst released", card_rst, 1);
    host_rst = 1'b0;
    #1;
    check("R7 rst follows low", card_rst, 0);
    host_rst = 1'b1;
    #1;
    check("R7 rst follows high", card_rst, 1);
    step(1);
    cmd_n = 1'b1;
    teardown("normal", 1, 1);
    host_rst = 1'b0;
    step(2);
  endtask

  task automatic t_late;
    activate("late", 1'b0, 1'b0, 1'b1, 0);
    step(39);
    check("R6 io on", io_en, 1);
    check("R6 clk waits", clk_en, 0);
    host_rst = 1'b0;
    step(1);
    check("R6 clk starts", clk_en, 1);
    step(16);
    check("R7 rst follows low", card_rst, 0);
    host_rst = 1'b1;
    #1;
    check("R7 rst follows high", card_rst, 1);
    check("R6 clk kept", clk_en, 1);
    step(1);
    cmd_n = 1'b1;
    teardown("late", 1, 1);
    host_rst = 1'b0;
    step(2);
  endtask

  task automatic t_noclock;
    activate("noclk", 1'b1, 1'b0, 1'b1, 2);
    step(56);
    check("R7 rst handed over", card_rst, 1);
    check("R6 clk never started", clk_en, 0);
    host_rst = 1'b0;
    step(2);
    check("R6 late low no effect", clk_en, 0);
    cmd_n = 1'b1;
    teardown("noclk", 0, 1);
    step(2);
  endtask

  task automatic t_fault_early;
    activate("fault", 1'b0, 1'b1, 1'b0, 1);
    step(19);
    fault = 1'b1;
    teardown("R9 fault", 0, 0);
    fault = 1'b0;
    cmd_n = 1'b1;
    step(2);
  endtask

  task automatic t_removal;
    activate("remove", 1'b0, 1'b1, 1'b0, 1);
    step(60);
    card_present = 1'b0;
    teardown("R9 removal", 1, 1);
    cmd_n = 1'b1;
    step(1);
    cmd_n = 1'b0;
    step(3);
    check("R10 no card ignored", vreg_en, 0);
    card_present = 1'b1;
    step(3);
    check("R10 no fresh edge", vreg_en, 0);
    cmd_n = 1'b1;
    step(2);
  endtask

  task automatic t_alarm;
    activate("alarm", 1'b0, 1'b0, 1'b0, 0);
    step(60);
    supply_alarm = 1'b1;
    teardown("R9 alarm", 1, 1);
    cmd_n = 1'b1;
    step(10);
    supply_alarm = 1'b0;
    step(5);
    cmd_n = 1'b0;
    step(3);
    check("R12 holdoff after alarm", vreg_en, 0);
    cmd_n = 1'b1;
    step(30);
  endtask

  task automatic t_stop;
    sel_18 = 1'b1; sel_5v3n = 1'b1;
    step(1);
    check("R11 stop entered", stop_mode, 1);
    check("R11 stop unpowered", vreg_en, 0);
    step(3);
    check("R11 stop kept", stop_mode, 1);
    sel_5v3n = 1'b0;
    step(1);
    check("R11 stop left", stop_mode, 0);
    cmd_n = 1'b0;
    step(2);
    check("R11 holdoff after stop", vreg_en, 0);
    cmd_n = 1'b1;
    sel_18 = 1'b0;
    step(30);
    activate("stopwait", 1'b1, 1'b1, 1'b0, 2);
    step(60);
    cmd_n = 1'b1;
    teardown("stopwait", 1, 1);
    check("R11 no stop during teardown", stop_mode, 0);
    step(1);
    check("R11 stop after teardown", stop_mode, 1);
    sel_18 = 1'b0; sel_5v3n = 1'b0;
    step(30);
  endtask

  initial begin
    t_reset();
    t_early();
    t_late();
    t_noclock();
    t_fault_early();
    t_removal();
    t_alarm();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule